// File: doc/BRIEF.md
# Dual-Space External Memory Controller

This block sits between an internal processor bus and external asynchronous memory. Each host request is decoded to one of two external devices: a code device (nonvolatile program store) or a data device (SRAM). Each device has its own active-low chip select. Both devices share one word-address bus, a 16-bit data bus, a single active-low read output enable and a single active-low write strobe. Part of the data space is an overlay window. Data-space accesses that fall inside it reach the code device, so the processor can read code through its data path.

Each space is configured on its own to be either a true 16-bit memory or a 16-bit space built from two 8-bit parts. In the byte-split form, the lowest address pin serves as the high-byte write strobe on write cycles, and the normal write strobe writes only the low byte. Every access follows a fixed sequence: a setup clock, a strobe of one clock plus 0 to 7 wait states, and a hold clock. The host side uses a valid/ready request and a one-cycle response pulse, with one access in flight at a time.

Top module: `extmem_ctrl`

## Requirements
- R1: While reset is held, and in every idle cycle, both chip selects, the output enable, the write strobe and the address-bit-0 pin are high, the data-bus drive enable is low, ready is high and the response valid is low.
- R2: Host word address bit 17 set selects the code device. Bit 17 clear selects the data device unless the address is in the overlay window. The two chip selects are never low together.
- R3: Data-space addresses 0x1C000 to 0x1FFFF form the overlay window. They assert the code chip select, and the pins carry the address minus 0x1C000. Address 0x1BFFF still goes to the data device. Overlay accesses use the code space's width and wait configuration.
- R4: An accepted request gives one setup cycle, with chip select low and the address valid but both strobes high. This is followed by a strobe phase of W+1 cycles, where W is the target space's wait count. Then comes one hold cycle with both strobes high and chip select still low. The address pins stay constant from setup through hold.
- R5: On a read, the output enable is low for the whole strobe phase. The bus value on its last low cycle is returned on the read-data output in the hold cycle, together with a one-cycle response-valid pulse.
- R6: On a write, the data bus is driven with the write data, with the drive enable high, from the setup cycle through the hold cycle. On a read the drive enable stays low.
- R7: In a 16-bit-wide space, a write asserts the write strobe when either byte-enable bit (bit 0 = low byte, bit 1 = high byte) is set. With both bits clear, no strobe is asserted. The address-bit-0 pin stays high for every access to that space.
- R8: In a byte-split space, a write drives the write strobe low only if byte enable bit 0 is set. It drives the address-bit-0 pin low, for the same strobe cycles, only if byte enable bit 1 is set.
- R9: In a byte-split space, a read leaves the address-bit-0 pin high and uses the output enable alone.
- R10: The wait count W (0 to 7) comes from the code-space or data-space configuration input, chosen by the device actually selected.
- R11: Ready is high only in idle. A valid request presented while an access is in progress is ignored: it starts no access, and the block returns to idle after the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 18 | Host word address; bit 17 selects code space |
| req_be_i | input | 2 | Byte enables, bit 0 low byte |
| req_wdata_i | input | 16 | Write data |
| rsp_valid_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 16 | Read data, valid with rsp_valid_o |
| code_split_i | input | 1 | Code space built from 8-bit parts |
| data_split_i | input | 1 | Data space built from 8-bit parts |
| code_wait_i | input | 3 | Code space wait states |
| data_wait_i | input | 3 | Data space wait states |
| mem_addr_o | output | 17 | Word address on address pins 1..17 |
| mem_a0_o | output | 1 | Address-bit-0 pin; high-byte write strobe (active low) in split mode |
| mem_dq_o | output | 16 | Data bus out |
| mem_dq_i | input | 16 | Data bus in |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_code_cs_n_o | output | 1 | Code device chip select, active low |
| mem_data_cs_n_o | output | 1 | Data device chip select, active low |
| mem_oe_n_o | output | 1 | Read output enable, active low |
| mem_we_n_o | output | 1 | Write strobe, active low |

## Verification
Reads and writes are tried against both spaces in both widths, with wait counts of 0, 3 and 7, so strobe length and device choice can be told apart. Byte-enable patterns 01, 10, 11 and 00 separate the low-lane strobe from the high-lane use of the address-bit-0 pin, and show the no-strobe case in word mode. Addresses just below and just inside the overlay window distinguish overlay remapping from ordinary data-space decode. A request held valid during a busy access checks that only one access is in flight.

// File: rtl/extmem_pkg.sv
package extmem_pkg;
  localparam int DQ_W   = 16;
  localparam int LANES  = DQ_W / 8;
  localparam int WAIT_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETUP  = 2'd1,
    ST_STROBE = 2'd2,
    ST_HOLD   = 2'd3
  } phase_e;

  typedef struct packed {
    logic             we;
    logic [LANES-1:0] be;
    logic [DQ_W-1:0]  wdata;
  } req_t;
endpackage

// File: rtl/extmem_decode.sv
module extmem_decode
  import extmem_pkg::*;
#(
  parameter int MEM_AW = 17,
  parameter int OVL_AW = 14,
  parameter bit OVL_EN = 1'b1
) (
  input  logic [MEM_AW:0]   addr_i,
  input  logic              code_split_i,
  input  logic              data_split_i,
  input  logic [WAIT_W-1:0] code_wait_i,
  input  logic [WAIT_W-1:0] data_wait_i,
  output logic              sel_code_o,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              split_o,
  output logic [WAIT_W-1:0] wait_o
);
  localparam int PAD_W = MEM_AW - OVL_AW;

  logic in_ovl;

  generate
    if (OVL_EN) begin : g_ovl
      // window is the top 2**OVL_AW words of data space
      assign in_ovl = ~addr_i[MEM_AW] & (&addr_i[MEM_AW-1:OVL_AW]);
    end else begin : g_no_ovl
      assign in_ovl = 1'b0;
    end
  endgenerate

  assign sel_code_o = addr_i[MEM_AW] | in_ovl;
  assign mem_addr_o = in_ovl ? {{PAD_W{1'b0}}, addr_i[OVL_AW-1:0]}
                             : addr_i[MEM_AW-1:0];
  assign split_o    = sel_code_o ? code_split_i : data_split_i;
  assign wait_o     = sel_code_o ? code_wait_i  : data_wait_i;
endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
  import extmem_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] wait_i,
  output phase_e            phase_o,
  output logic              capture_o
);
  phase_e            ph_q;
  logic [WAIT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      case (ph_q)
        ST_IDLE:   if (start_i) ph_q <= ST_SETUP;
        ST_SETUP: begin
          ph_q  <= ST_STROBE;
          cnt_q <= wait_i;
        end
        ST_STROBE: begin
          if (cnt_q == '0) ph_q <= ST_HOLD;
          else             cnt_q <= cnt_q - 1'b1;
        end
        default:   ph_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o   = ph_q;
  assign capture_o = (ph_q == ST_STROBE) && (cnt_q == '0);
endmodule

// File: rtl/extmem_pins.sv
module extmem_pins
  import extmem_pkg::*;
(
  input  phase_e           phase_i,
  input  logic             sel_code_i,
  input  logic             split_i,
  input  logic             we_i,
  input  logic [LANES-1:0] be_i,
  output logic             code_cs_n_o,
  output logic             data_cs_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             a0_o,
  output logic             dq_oe_o
);
  logic active, strobe, lo_wr, hi_wr;

  assign active = (phase_i != ST_IDLE);
  assign strobe = (phase_i == ST_STROBE);

  // byte-lane steering: split parts get one strobe per lane
  assign lo_wr = split_i ? be_i[0] : |be_i;
  assign hi_wr = split_i & be_i[1];

  assign code_cs_n_o = ~(active &  sel_code_i);
  assign data_cs_n_o = ~(active & ~sel_code_i);
  assign oe_n_o      = ~(strobe & ~we_i);
  assign we_n_o      = ~(strobe &  we_i & lo_wr);
  assign a0_o        = ~(strobe &  we_i & hi_wr);
  assign dq_oe_o     = active & we_i;
endmodule

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
  import extmem_pkg::*;
#(
  parameter int MEM_AW = 17,
  parameter int OVL_AW = 14,
  parameter bit OVL_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [MEM_AW:0]   req_addr_i,
  input  logic [LANES-1:0]  req_be_i,
  input  logic [DQ_W-1:0]   req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DQ_W-1:0]   rsp_rdata_o,
  input  logic              code_split_i,
  input  logic              data_split_i,
  input  logic [WAIT_W-1:0] code_wait_i,
  input  logic [WAIT_W-1:0] data_wait_i,
  output logic [MEM_AW-1:0] mem_addr_o,
  output logic              mem_a0_o,
  output logic [DQ_W-1:0]   mem_dq_o,
  input  logic [DQ_W-1:0]   mem_dq_i,
  output logic              mem_dq_oe_o,
  output logic              mem_code_cs_n_o,
  output logic              mem_data_cs_n_o,
  output logic              mem_oe_n_o,
  output logic              mem_we_n_o
);
  phase_e            phase;
  logic              capture, accept;
  logic              dec_code, dec_split;
  logic [MEM_AW-1:0] dec_addr;
  logic [WAIT_W-1:0] dec_wait;

  req_t              req_q;
  logic              code_q, split_q;
  logic [MEM_AW-1:0] addr_q;
  logic [WAIT_W-1:0] wait_q;
  logic [DQ_W-1:0]   rdata_q;

  extmem_decode #(.MEM_AW(MEM_AW), .OVL_AW(OVL_AW), .OVL_EN(OVL_EN)) u_dec (
    .addr_i       (req_addr_i),
    .code_split_i (code_split_i),
    .data_split_i (data_split_i),
    .code_wait_i  (code_wait_i),
    .data_wait_i  (data_wait_i),
    .sel_code_o   (dec_code),
    .mem_addr_o   (dec_addr),
    .split_o      (dec_split),
    .wait_o       (dec_wait)
  );

  assign req_ready_o = (phase == ST_IDLE);
  assign accept      = req_valid_i & req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      code_q  <= 1'b0;
      split_q <= 1'b0;
      addr_q  <= '0;
      wait_q  <= '0;
    end else if (accept) begin
      req_q   <= '{we: req_we_i, be: req_be_i, wdata: req_wdata_i};
      code_q  <= dec_code;
      split_q <= dec_split;
      addr_q  <= dec_addr;
      wait_q  <= dec_wait;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      rdata_q <= '0;
    else if (capture && !req_q.we)    rdata_q <= mem_dq_i;
  end

  extmem_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .wait_i    (wait_q),
    .phase_o   (phase),
    .capture_o (capture)
  );

  extmem_pins u_pins (
    .phase_i     (phase),
    .sel_code_i  (code_q),
    .split_i     (split_q),
    .we_i        (req_q.we),
    .be_i        (req_q.be),
    .code_cs_n_o (mem_code_cs_n_o),
    .data_cs_n_o (mem_data_cs_n_o),
    .oe_n_o      (mem_oe_n_o),
    .we_n_o      (mem_we_n_o),
    .a0_o        (mem_a0_o),
    .dq_oe_o     (mem_dq_oe_o)
  );

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = req_q.wdata;
  assign rsp_valid_o = (phase == ST_HOLD);
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/extmem_ctrl_chk.sv
module extmem_ctrl_chk #(
  parameter int MEM_AW = 17
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [MEM_AW-1:0] mem_addr_o,
  input logic              mem_a0_o,
  input logic              mem_dq_oe_o,
  input logic              mem_code_cs_n_o,
  input logic              mem_data_cs_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_we_n_o,
  input logic              code_split_i,
  input logic              data_split_i
);
  logic       cs_any, strobe_any;
  logic [3:0] run_q;

  assign cs_any     = ~mem_code_cs_n_o | ~mem_data_cs_n_o;
  assign strobe_any = ~mem_oe_n_o | ~mem_we_n_o | ~mem_a0_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         run_q <= '0;
    else if (!strobe_any) run_q <= '0;
    else if (run_q != 4'hF) run_q <= run_q + 1'b1;
  end

  assert_cs_exclusive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(~mem_code_cs_n_o & ~mem_data_cs_n_o));

  assert_strobe_needs_cs_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_any |-> cs_any);

  assert_we_setup_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mem_we_n_o) |-> ($past(cs_any) && $stable(mem_addr_o)));

  assert_we_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (cs_any && $stable(mem_addr_o)));

  assert_read_no_drive_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_dq_oe_o && mem_we_n_o && mem_a0_o));

  assert_word_a0_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((!mem_code_cs_n_o && !code_split_i) || (!mem_data_cs_n_o && !data_split_i)) |-> mem_a0_o);

  assert_wait_bound_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= 4'd8);

  assert_ready_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!cs_any && !rsp_valid_o));
endmodule

bind extmem_ctrl extmem_ctrl_chk #(.MEM_AW(MEM_AW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_ready_o     (req_ready_o),
  .rsp_valid_o     (rsp_valid_o),
  .mem_addr_o      (mem_addr_o),
  .mem_a0_o        (mem_a0_o),
  .mem_dq_oe_o     (mem_dq_oe_o),
  .mem_code_cs_n_o (mem_code_cs_n_o),
  .mem_data_cs_n_o (mem_data_cs_n_o),
  .mem_oe_n_o      (mem_oe_n_o),
  .mem_we_n_o      (mem_we_n_o),
  .code_split_i    (code_split_i),
  .data_split_i    (data_split_i)
);

// File: tb/extmem_ctrl_tb.sv
module extmem_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0;
  logic [17:0] req_addr_i = '0;
  logic [1:0]  req_be_i = '0;
  logic [15:0] req_wdata_i = '0;
  logic        code_split_i = 1'b0, data_split_i = 1'b0;
  logic [2:0]  code_wait_i = '0, data_wait_i = '0;
  logic        req_ready_o, rsp_valid_o, mem_a0_o, mem_dq_oe_o;
  logic        mem_code_cs_n_o, mem_data_cs_n_o, mem_oe_n_o, mem_we_n_o;
  logic [15:0] rsp_rdata_o, mem_dq_o, mem_dq_i;
  logic [16:0] mem_addr_o;

  int nvec = 0, nbad = 0, cyc = 0;

  always #10 clk_i = ~clk_i;

  // behavioural memory: a value that depends on device and address
  assign mem_dq_i = !mem_oe_n_o
    ? (mem_addr_o[15:0] ^ (!mem_code_cs_n_o ? 16'hC0DE : 16'hDA7A)) : 16'hBEEF;

  extmem_ctrl u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pins();
    return {mem_code_cs_n_o, mem_data_cs_n_o, mem_oe_n_o, mem_we_n_o,
            mem_a0_o, mem_dq_oe_o, req_ready_o, rsp_valid_o};
  endfunction

  localparam logic [7:0] IDLE_PINS = 8'b1111_1010;

  // one access, compared cycle by cycle against the requirement timeline
  task automatic access(input bit we, input logic [17:0] a, input logic [1:0] be,
                        input logic [15:0] wd, input bit poke);
    bit ovl, code, split;
    logic [16:0] pa;
    int w;
    logic [7:0] e;
    ovl   = !a[17] && (a[16:14] == 3'b111);
    code  = a[17] || ovl;
    pa    = ovl ? {3'b000, a[13:0]} : a[16:0];
    split = code ? code_split_i : data_split_i;
    w     = code ? int'(code_wait_i) : int'(data_wait_i);
    chk("R11 ready in idle", pins(), IDLE_PINS);
    req_valid_i = 1'b1; req_we_i = we; req_addr_i = a; req_be_i = be; req_wdata_i = wd;
    @(negedge clk_i);
    if (poke) begin
      req_addr_i = 18'h00123; req_we_i = ~we;
    end else req_valid_i = 1'b0;
    e = {~code, code, 1'b1, 1'b1, 1'b1, we, 1'b0, 1'b0};
    chk("R2 R3 R4 setup pins", pins(), e);
    chk("R3 R4 setup addr", mem_addr_o, pa);
    for (int k = 0; k <= w; k++) begin
      @(negedge clk_i);
      req_valid_i = 1'b0;
      e = {~code, code, we,
           ~(we & (split ? be[0] : (be != 2'b00))),
           ~(we & split & be[1]), we, 1'b0, 1'b0};
      chk(split ? (we ? "R8 R10 split write strobe" : "R9 R10 split read strobe")
                : (we ? "R7 R10 word write strobe" : "R5 R10 word read strobe"), pins(), e);
      chk("R4 strobe addr", mem_addr_o, pa);
      if (we) chk("R6 write data", mem_dq_o, wd);
    end
    @(negedge clk_i);
    e = {~code, code, 1'b1, 1'b1, 1'b1, we, 1'b0, 1'b1};
    chk("R4 hold pins", pins(), e);
    chk("R4 hold addr", mem_addr_o, pa);
    if (!we) chk("R5 read data", rsp_rdata_o, pa[15:0] ^ (code ? 16'hC0DE : 16'hDA7A));
    @(negedge clk_i);
    chk(poke ? "R11 busy request ignored" : "R1 back to idle", pins(), IDLE_PINS);
  endtask

  initial begin
    while (1) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 20000) begin
        nbad++;
        $display("FAIL watchdog act=%0d exp=<20000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset pins", pins(), IDLE_PINS);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after reset", pins(), IDLE_PINS);

    // word-wide data space, no waits
    access(1'b0, 18'h00042, 2'b11, 16'h0000, 1'b0);
    access(1'b1, 18'h00100, 2'b11, 16'hA55A, 1'b0);
    access(1'b1, 18'h00101, 2'b01, 16'h1234, 1'b0);
    access(1'b1, 18'h00102, 2'b10, 16'h5678, 1'b0);
    access(1'b1, 18'h00103, 2'b00, 16'h9ABC, 1'b0);
    // byte-split code space with waits (R8, R9, R10)
    code_split_i = 1'b1; code_wait_i = 3'd3;
    access(1'b0, 18'h20077, 2'b11, 16'h0000, 1'b0);
    access(1'b1, 18'h20010, 2'b01, 16'h00C3, 1'b0);
    access(1'b1, 18'h20011, 2'b10, 16'h3C00, 1'b0);
    access(1'b1, 18'h20012, 2'b11, 16'hF00F, 1'b0);
    // overlay boundary (R3): below window stays data, inside goes code
    data_wait_i = 3'd1;
    access(1'b0, 18'h1BFFF, 2'b11, 16'h0000, 1'b0);
    access(1'b0, 18'h1C005, 2'b11, 16'h0000, 1'b0);
    access(1'b1, 18'h1FFFF, 2'b10, 16'h7E00, 1'b0);
    // maximum wait count, word-wide code space
    code_split_i = 1'b0; code_wait_i = 3'd7;
    access(1'b0, 18'h3FFFF, 2'b11, 16'h0000, 1'b0);
    access(1'b1, 18'h20000, 2'b01, 16'h0101, 1'b0);
    // byte-split data space; request held while busy (R11)
    data_split_i = 1'b1; data_wait_i = 3'd2;
    access(1'b1, 18'h00200, 2'b10, 16'hAB00, 1'b1);
    @(negedge clk_i);
    chk("R11 no second access", pins(), IDLE_PINS);
    access(1'b0, 18'h00201, 2'b11, 16'h0000, 1'b1);
    @(negedge clk_i);
    chk("R11 no second access", pins(), IDLE_PINS);

    // reset during an access returns pins to idle
    req_valid_i = 1'b1; req_we_i = 1'b1; req_addr_i = 18'h00300; req_be_i = 2'b11;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    chk("R1 reset mid-access", pins(), IDLE_PINS);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 idle after second reset", pins(), IDLE_PINS);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule